// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache

This block is a small cache placed between a processor-side word port and a slower main-memory port. Addresses are 15 bits wide and words are 12 bits wide. The low address bits choose one set. Each set holds two entries, and each entry has a tag, a data word, a valid flag and a dirty flag. The upper address bits form the tag. They are compared against both entries of the chosen set in the same cycle.

The processor raises a request with an address, a read/write flag, write data and a policy flag. The block then holds `cpu_busy` high until the access completes. Completion is marked by a one-cycle `cpu_done` pulse, and for reads the word appears on `cpu_rdata` at that time.

- A hit is served from the array.
- A read miss fetches the word from memory, delivers it and installs it.
- A write miss installs the write data directly, without fetching.
- Under the write-through policy, every write is also sent to memory.
- Under the write-back policy, a write only updates the array and marks the entry dirty. The dirty entry is written to memory when it is chosen for replacement.

The memory port uses a request that is held until an acknowledge arrives, so memory latency may vary.

Top module: `cache2w_top`

## Requirements
- R1: After reset `cpu_busy`, `cpu_done` and `mem_req` are low and every entry is invalid. The first read of any address after reset therefore issues a memory read, and the memory never sees a request while `cpu_busy` is low.
- R2: The set index is `cpu_addr[8:0]` and the tag is `cpu_addr[14:9]`. Addresses with equal tags but different indexes occupy different sets and do not hit on each other.
- R3: A read hit issues no memory request. It returns the stored word with `cpu_done` high one clock after the state change that accepted the request, that is, on the second rising edge counted from the accepting edge.
- R4: A read miss issues exactly one memory read (`mem_we`=0) at the requested address. It returns the memory word to the processor and installs it, so the next read of that address hits.
- R5: Both entries of a set can hold different tags at once. After two misses to one set, both addresses hit.
- R6: The replacement victim is an invalid entry if the set has one. Otherwise it is the least recently used entry, where a hit, a fill or a write-allocate marks an entry as most recently used.
- R7: With `cpu_wb_mode`=0 (write-through), a write updates the array and issues one memory write with that address and data. The entry is left clean, so its later eviction issues no memory write, even if an earlier write-back write had made it dirty.
- R8: With `cpu_wb_mode`=1 (write-back), a write hit issues no memory request, completes in the same time as a read hit, and marks the entry dirty. A later read returns the new word while memory keeps the old one.
- R9: When a dirty entry is evicted, one memory write of its own address and stored word is issued before any memory read for the new address. Evicting a clean entry issues no memory write.
- R10: A write miss issues no memory read. It installs the write data (dirty under write-back, clean under write-through), and a following read hits with that data.
- R11: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until a cycle with `mem_ack` high. `cpu_busy` rises the cycle after a request is accepted and stays high through any memory wait. `cpu_busy` falls exactly in the one-cycle `cpu_done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled while not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | Word address: tag in [14:9], index in [8:0] |
| cpu_wdata | input | 12 | Write data |
| cpu_wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| cpu_busy | output | 1 | High from acceptance until completion |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 12 | Read result, valid with `cpu_done` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 12 | Memory read data, valid with `mem_ack` |

## Verification
The directed scenarios use several access patterns, and each one isolates a different behaviour:

- Repeated reads of one address separate hit from miss, because they differ in cycle count and memory traffic.
- Pairs and triples of tags in one set expose whether both ways are kept and which one the LRU state evicts.
- Reusing a tag under another index shows that the index field really separates sets.
- Write sequences under each policy, followed by forced evictions, distinguish write-through traffic from deferred write-back. These sequences also show that a dirty victim is written before the fetch, that a clean victim is dropped silently, and that a policy change clears the dirty state.
- A long memory latency and a mid-run reset test the handshake hold and the invalidation of every entry.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_EVICT,
      ST_FILL,
      ST_INST,
      ST_MWR
   } cstate_e;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
   parameter int IW = 9,
   parameter int TW = 6,
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_valid,
   output logic          rd_dirty,
   output logic [TW-1:0] rd_tag,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [TW-1:0] wr_tag,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_dirty
);
   localparam int SETS = 1 << IW;

   logic [SETS-1:0] valid_q;
   logic [SETS-1:0] dirty_q;
   logic [TW-1:0]   tag_q  [SETS];
   logic [DW-1:0]   data_q [SETS];

   // flags are cleared by reset; tag and data need no reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
   parameter int IW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_old,
   input  logic          upd_en,
   input  logic [IW-1:0] upd_idx,
   input  logic          upd_way
);
   localparam int SETS = 1 << IW;

   // one bit per set: the way that was used least recently
   logic [SETS-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      old_q <= '0;
      else if (upd_en) old_q[upd_idx] <= ~upd_way;
   end

   assign rd_old = old_q[rd_idx];
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int AW = 15,
   parameter int DW = 12,
   parameter int IW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          cpu_wb_mode,
   output logic          cpu_busy,
   output logic          cpu_done,
   output logic [DW-1:0] cpu_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);
   localparam int TW   = AW - IW;
   localparam int NWAY = 2;

   if (IW < 1 || IW >= AW) begin : g_bad_iw
      $error("cache2w_top: IW must lie in 1..AW-1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cache2w_top: DW must be positive");
   end

   cstate_e       state_q;
   logic [AW-1:0] acc_addr;
   logic          acc_we;
   logic [DW-1:0] acc_wdata;
   logic          acc_wb;
   logic          vic_q;
   logic [TW-1:0] vic_tag_q;
   logic [DW-1:0] vic_data_q;
   logic [DW-1:0] rdata_q;
   logic          done_q;

   logic [IW-1:0] acc_idx;
   logic [TW-1:0] acc_tag;
   assign acc_idx = acc_addr[IW-1:0];
   assign acc_tag = acc_addr[AW-1:IW];

   logic [NWAY-1:0] w_valid, w_dirty, w_hit, w_wen;
   logic [TW-1:0]   w_tag  [NWAY];
   logic [DW-1:0]   w_data [NWAY];

   logic          wen_any, wsel, wdirty_c, lru_upd, lru_old;
   logic [DW-1:0] wdata_c;

   for (genvar g = 0; g < NWAY; g++) begin : g_way
      cache2w_way #(.IW(IW), .TW(TW), .DW(DW)) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (acc_idx),
         .rd_valid (w_valid[g]),
         .rd_dirty (w_dirty[g]),
         .rd_tag   (w_tag[g]),
         .rd_data  (w_data[g]),
         .wr_en    (w_wen[g]),
         .wr_idx   (acc_idx),
         .wr_tag   (acc_tag),
         .wr_data  (wdata_c),
         .wr_dirty (wdirty_c)
      );
      assign w_hit[g] = w_valid[g] && (w_tag[g] == acc_tag);
      assign w_wen[g] = wen_any && (wsel == 1'(g));
   end

   cache2w_lru #(.IW(IW)) u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (acc_idx),
      .rd_old  (lru_old),
      .upd_en  (lru_upd),
      .upd_idx (acc_idx),
      .upd_way (wsel)
   );

   logic hit_any, hit_way, vic_c;
   assign hit_any = |w_hit;
   assign hit_way = w_hit[1];
   // an empty way is preferred, then the least recently used one
   assign vic_c   = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_old);

   always_comb begin
      wen_any  = 1'b0;
      wsel     = hit_way;
      wdata_c  = acc_wdata;
      wdirty_c = acc_wb;
      lru_upd  = 1'b0;
      case (state_q)
         ST_LOOK: if (hit_any) begin
            lru_upd = 1'b1;
            wen_any = acc_we;
         end
         ST_FILL: if (mem_ack) begin
            wen_any  = 1'b1;
            wsel     = vic_q;
            wdata_c  = mem_rdata;
            wdirty_c = 1'b0;
            lru_upd  = 1'b1;
         end
         ST_INST: begin
            wen_any = 1'b1;
            wsel    = vic_q;
            lru_upd = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         acc_addr   <= '0;
         acc_we     <= 1'b0;
         acc_wdata  <= '0;
         acc_wb     <= 1'b0;
         vic_q      <= 1'b0;
         vic_tag_q  <= '0;
         vic_data_q <= '0;
         rdata_q    <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (cpu_req) begin
               acc_addr  <= cpu_addr;
               acc_we    <= cpu_we;
               acc_wdata <= cpu_wdata;
               acc_wb    <= cpu_wb_mode;
               state_q   <= ST_LOOK;
            end
            ST_LOOK: begin
               if (hit_any) begin
                  if (!acc_we) begin
                     rdata_q <= w_data[hit_way];
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (acc_wb) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_MWR;
                  end
               end else begin
                  vic_q      <= vic_c;
                  vic_tag_q  <= w_tag[vic_c];
                  vic_data_q <= w_data[vic_c];
                  if (w_valid[vic_c] && w_dirty[vic_c]) state_q <= ST_EVICT;
                  else state_q <= acc_we ? ST_INST : ST_FILL;
               end
            end
            ST_EVICT: if (mem_ack) state_q <= acc_we ? ST_INST : ST_FILL;
            ST_FILL: if (mem_ack) begin
               rdata_q <= mem_rdata;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_INST: begin
               if (acc_wb) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_MWR;
               end
            end
            ST_MWR: if (mem_ack) begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (state_q != ST_IDLE);
   assign cpu_done  = done_q;
   assign cpu_rdata = rdata_q;
   assign mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_MWR);
   assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_MWR);
   assign mem_addr  = (state_q == ST_EVICT) ? {vic_tag_q, acc_idx} : acc_addr;
   assign mem_wdata = (state_q == ST_EVICT) ? vic_data_q : acc_wdata;
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
   parameter int AW = 15,
   parameter int DW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_busy,
   input logic          cpu_done,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          acc_we,
   input logic [AW-1:0] acc_addr
);
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> !mem_req);

   a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_busy) |-> cpu_done);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy && cpu_req |=> cpu_busy);

   a_r10_no_fetch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> !acc_we);

   a_r4_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_addr == acc_addr);
endmodule

bind cache2w_top cache2w_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_busy  (cpu_busy),
   .cpu_done  (cpu_done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .acc_we    (acc_we),
   .acc_addr  (acc_addr)
);

// File: tb/cache2w_top_tb.sv
`timescale 1ns/1ps
module cache2w_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [14:0] cpu_addr = '0;
   logic [11:0] cpu_wdata = '0;
   logic        cpu_wb_mode = 1'b0;
   logic        cpu_busy, cpu_done;
   logic [11:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [14:0] mem_addr;
   logic [11:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [11:0] mem_rdata = '0;

   cache2w_top u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wb_mode(cpu_wb_mode),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   initial forever #2 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // main memory model with operation log
   logic [11:0] mmem [int];
   int          op_n = 0;
   int          lat_base = 1;
   logic        op_we_l   [int];
   int          op_addr_l [int];
   logic [11:0] op_data_l [int];

   function automatic logic [11:0] mval(int a);
      if (mmem.exists(a)) return mmem[a];
      return a[11:0] ^ 12'hA5C;
   endfunction

   function automatic logic [14:0] ad(int t, int i);
      return {t[5:0], i[8:0]};
   endfunction

   initial forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
         int wt;
         int a;
         wt = lat_base + (op_n % 3);
         for (int k = 0; k < wt; k++) @(negedge clk);
         a = int'(mem_addr);
         op_we_l[op_n]   = mem_we;
         op_addr_l[op_n] = a;
         op_data_l[op_n] = mem_wdata;
         if (mem_we) mmem[a] = mem_wdata;
         else mem_rdata = mval(a);
         op_n++;
         mem_ack = 1'b1;
         @(negedge clk);
         mem_ack = 1'b0;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [14:0] a, input logic [11:0] d,
                      input logic wb, output logic [11:0] rd, output int cyc,
                      output int ops, output logic busy_ok);
      int op0;
      op0 = op_n;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_wb_mode = wb;
      @(negedge clk);
      cpu_req = 1'b0;
      cyc = 1;
      busy_ok = 1'b1;
      while (!cpu_done && cyc < 2000) begin
         if (!cpu_busy) busy_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 2000) chk("R11", "access never completed", 0, 1);
      rd = cpu_rdata;
      ops = op_n - op0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   logic [11:0] rd;
   int          cyc, ops, op0;
   logic        bok;

   task automatic t_reset();
      do_reset();
      chk("R1", "busy after reset", int'(cpu_busy), 0);
      chk("R1", "done after reset", int'(cpu_done), 0);
      chk("R1", "mem_req after reset", int'(mem_req), 0);
   endtask

   task automatic t_read_miss_hit();
      op0 = op_n;
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R4", "miss data", int'(rd), int'(mval(int'(ad(1,5)))));
      chk("R4", "miss ops", ops, 1);
      chk("R4", "miss op is read", int'(op_we_l[op0]), 0);
      chk("R4", "miss address", op_addr_l[op0], int'(ad(1,5)));
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R3", "hit data", int'(rd), int'(mval(int'(ad(1,5)))));
      chk("R3", "hit ops", ops, 0);
      chk("R3", "hit cycles", cyc, 2);
   endtask

   task automatic t_two_ways();
      acc(0, ad(2,5), 0, 0, rd, cyc, ops, bok);
      chk("R5", "second tag miss ops", ops, 1);
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R5", "first tag still hits", ops, 0);
      acc(0, ad(2,5), 0, 0, rd, cyc, ops, bok);
      chk("R5", "second tag hits", ops, 0);
      chk("R5", "second tag data", int'(rd), int'(mval(int'(ad(2,5)))));
      acc(0, ad(1,6), 0, 0, rd, cyc, ops, bok);
      chk("R2", "same tag other index misses", ops, 1);
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R2", "original set untouched", ops, 0);
   endtask

   task automatic t_lru();
      // set 5 holds tags 1 and 2; touching tag 1 leaves tag 2 least recent
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      op0 = op_n;
      acc(0, ad(3,5), 0, 0, rd, cyc, ops, bok);
      chk("R9", "clean victim gives one op", ops, 1);
      chk("R9", "clean victim op is read", int'(op_we_l[op0]), 0);
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R6", "recent way kept", ops, 0);
      acc(0, ad(2,5), 0, 0, rd, cyc, ops, bok);
      chk("R6", "lru way evicted", ops, 1);
   endtask

   task automatic t_write_through_hit();
      op0 = op_n;
      acc(1, ad(1,5), 12'h123, 0, rd, cyc, ops, bok);
      chk("R7", "wt hit ops", ops, 1);
      chk("R7", "wt op is write", int'(op_we_l[op0]), 1);
      chk("R7", "wt addr", op_addr_l[op0], int'(ad(1,5)));
      chk("R7", "wt data", int'(op_data_l[op0]), 'h123);
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R7", "wt readback hit", ops, 0);
      chk("R7", "wt readback data", int'(rd), 'h123);
   endtask

   task automatic t_write_back();
      acc(0, ad(4,7), 0, 1, rd, cyc, ops, bok);
      acc(1, ad(4,7), 12'h3C3, 1, rd, cyc, ops, bok);
      chk("R8", "wb hit ops", ops, 0);
      chk("R8", "wb hit cycles", cyc, 2);
      acc(0, ad(4,7), 0, 1, rd, cyc, ops, bok);
      chk("R8", "wb readback", int'(rd), 'h3C3);
      chk("R8", "memory still old", int'(mval(int'(ad(4,7)))), int'(ad(4,7) & 15'h0FFF) ^ 'hA5C);
      acc(0, ad(5,7), 0, 1, rd, cyc, ops, bok);
      chk("R6", "empty way filled first", ops, 1);
      op0 = op_n;
      acc(0, ad(6,7), 0, 1, rd, cyc, ops, bok);
      chk("R9", "dirty evict ops", ops, 2);
      chk("R9", "writeback first", int'(op_we_l[op0]), 1);
      chk("R9", "writeback addr", op_addr_l[op0], int'(ad(4,7)));
      chk("R9", "writeback data", int'(op_data_l[op0]), 'h3C3);
      chk("R9", "then fetch", int'(op_we_l[op0+1]), 0);
      chk("R9", "fetch addr", op_addr_l[op0+1], int'(ad(6,7)));
      acc(0, ad(4,7), 0, 1, rd, cyc, ops, bok);
      chk("R9", "refetch after writeback", int'(rd), 'h3C3);
      chk("R9", "clean victim no write", ops, 1);
   endtask

   task automatic t_write_miss();
      acc(1, ad(7,9), 12'h0F0, 1, rd, cyc, ops, bok);
      chk("R10", "wb write miss ops", ops, 0);
      acc(0, ad(7,9), 0, 1, rd, cyc, ops, bok);
      chk("R10", "allocated entry hits", ops, 0);
      chk("R10", "allocated data", int'(rd), 'h0F0);
      op0 = op_n;
      acc(1, ad(8,10), 12'h777, 0, rd, cyc, ops, bok);
      chk("R10", "wt write miss ops", ops, 1);
      chk("R10", "wt write miss no read", int'(op_we_l[op0]), 1);
      chk("R10", "wt write miss data", int'(op_data_l[op0]), 'h777);
      acc(0, ad(8,10), 0, 0, rd, cyc, ops, bok);
      chk("R10", "wt allocated hit", ops, 0);
      chk("R10", "wt allocated data", int'(rd), 'h777);
   endtask

   task automatic t_policy_switch();
      acc(0, ad(10,11), 0, 1, rd, cyc, ops, bok);
      acc(1, ad(10,11), 12'h111, 1, rd, cyc, ops, bok);
      chk("R8", "dirtying write quiet", ops, 0);
      acc(1, ad(10,11), 12'h222, 0, rd, cyc, ops, bok);
      chk("R7", "wt after wb writes memory", ops, 1);
      acc(0, ad(11,11), 0, 1, rd, cyc, ops, bok);
      op0 = op_n;
      acc(0, ad(12,11), 0, 1, rd, cyc, ops, bok);
      chk("R7", "entry left clean evicts silently", ops, 1);
      chk("R7", "only a fetch", int'(op_we_l[op0]), 0);
   endtask

   task automatic t_latency();
      lat_base = 20;
      acc(0, ad(9,12), 0, 0, rd, cyc, ops, bok);
      chk("R11", "long wait cycles", int'(cyc > 20), 1);
      chk("R11", "busy held during wait", int'(bok), 1);
      chk("R11", "data after wait", int'(rd), int'(mval(int'(ad(9,12)))));
      lat_base = 1;
   endtask

   task automatic t_reset_invalidates();
      do_reset();
      chk("R1", "busy after second reset", int'(cpu_busy), 0);
      op0 = op_n;
      acc(0, ad(1,5), 0, 0, rd, cyc, ops, bok);
      chk("R1", "cached line invalid after reset", ops, 1);
      chk("R1", "read from memory", int'(rd), 'h123);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_read_miss_hit();
      t_two_ways();
      t_lru();
      t_write_through_hit();
      t_write_back();
      t_write_miss();
      t_policy_switch();
      t_latency();
      t_reset_invalidates();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule